// File: doc/BRIEF.md
# Relocatable Console I/O Port Window

This block decodes a window of sixteen consecutive I/O ports on an 8-bit bus. It sits between the bus and a handful of internal consumers: a console character sink, a keyboard source, and an auxiliary character display with its controller. The window's position comes from an eight-position switch. Only the switch's upper four positions take part in the match against the address's upper nibble. With the switch set to 80H the ports occupy 80H–8FH. With the switch at 00H the status and data ports land where a legacy console expects them, at offsets 0 and 1.

A write of a character to either character port latches the byte and raises that channel's ready flag. The flag stays high until the consumer pulls its clear line low. Each character written is also copied to a 10-segment LED bar, with two extra segments that show which channel received it. Reads are combinational: the read data and the bus drive enable are valid in the same cycle as the read strobe. Addresses outside the window are not answered.

Top module: `cons_port_window`

## Requirements
- R1: An access hits the window when addr[7:4] equals base_sw[7:4]. base_sw[3:0] has no effect. A read that hits raises bus_oe in the same cycle.
- R2: An access outside the window changes no output or register. During such a read, bus_oe is 0, bus_rdata is 00H and kbd_ack is 0. Whenever bus_oe is 0, bus_rdata is 00H.
- R3: A read of offset 0 returns bit 1 = NOT con_rdy (console can accept a character), bit 0 = kbd_avail, and zeros in bits 7:2.
- R4: A read of offset 6 returns opt_sw in bits 3:0 and zeros in bits 7:4.
- R5: A write to offset 1 puts the data byte on con_data and sets con_rdy from the next cycle on. A write while con_rdy is already 1 replaces the byte and keeps con_rdy at 1.
- R6: con_clr_n low at a clock edge clears con_rdy and leaves con_data unchanged. If a write to offset 1 lands in the same edge, the write wins. aux_clr_n does the same for aux_rdy.
- R7: A write to offset 8 loads wdata[0] into aux_en. A read of offset 8 returns {7'b0, aux_en}.
- R8: A write to offset 0EH puts the byte on aux_data and sets aux_rdy, following the same overwrite rule as R5.
- R9: A write to offset 0FH loads wdata[0] into aux_rst. A read of offset 0FH returns {7'b0, aux_rst}.
- R10: A read of offset 9 returns {7'b0, kbd_avail}. A read of offset 0AH returns kbd_code and raises kbd_ack during that read cycle only.
- R11: Each write to offset 1 or 0EH loads led_bar with {2'b01, byte} or {2'b10, byte} respectively. No other access changes led_bar.
- R12: While rst_n is low at a clock edge, every registered output clears to 0.
- R13: Offsets 2–5, 7 and 0BH–0DH read as 00H with bus_oe high. Writes to these offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | I/O port address |
| wdata | input | 8 | Write data from the bus |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, 00H when not driven |
| bus_oe | output | 1 | Read data drive enable |
| base_sw | input | 8 | Window base switch; bits 7:4 are compared |
| opt_sw | input | 4 | Option switch returned by the configuration port |
| kbd_avail | input | 1 | Keyboard has a code waiting |
| kbd_code | input | 8 | Waiting keyboard code |
| kbd_ack | output | 1 | Keyboard data port is being read |
| con_data | output | 8 | Latched console character |
| con_rdy | output | 1 | Console character waiting |
| con_clr_n | input | 1 | Console consumer clear, active low |
| aux_data | output | 8 | Latched auxiliary display character |
| aux_rdy | output | 1 | Auxiliary character waiting |
| aux_clr_n | input | 1 | Auxiliary consumer clear, active low |
| aux_en | output | 1 | Auxiliary display enable |
| aux_rst | output | 1 | Auxiliary display controller reset |
| led_bar | output | 10 | Last character plus destination bits |

## Verification
Read results are due in the same cycle as io_rd. The bench drives each access just after a falling edge and samples bus_rdata, bus_oe and kbd_ack 1 ns later, before the next rising edge. Writes, clears and reset take effect at the next rising edge. The bench updates its model at that edge and compares every registered output at the following falling edge, so each result is checked exactly one edge after its cause. Random traffic moves the base switch, pulses the clear lines at random and mixes in- and out-of-window addresses. Directed cases cover overwrite-while-ready, a clear coinciding with a write, relocation to 00H and the unused offsets.

// File: rtl/cpw_pkg.sv
// Shared widths, port offsets and strobe type for the console port window.
// Assumes a 16-port window, so the offset field is fixed at four bits.
package cpw_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 4;
    localparam int OPT_W  = 4;
    localparam int N_CHAN = 2;
    localparam int CH_CON = 0;
    localparam int CH_AUX = 1;
    localparam int LED_W  = DATA_W + N_CHAN;

    // Offsets that software decodes; these positions are behaviour.
    localparam logic [OFS_W-1:0] OFS_CON_STAT = 4'h0;
    localparam logic [OFS_W-1:0] OFS_CON_DATA = 4'h1;
    localparam logic [OFS_W-1:0] OFS_CFG      = 4'h6;
    localparam logic [OFS_W-1:0] OFS_AUX_EN   = 4'h8;
    localparam logic [OFS_W-1:0] OFS_KBD_STAT = 4'h9;
    localparam logic [OFS_W-1:0] OFS_KBD_DATA = 4'hA;
    localparam logic [OFS_W-1:0] OFS_AUX_DATA = 4'hE;
    localparam logic [OFS_W-1:0] OFS_AUX_RST  = 4'hF;

    typedef struct packed {
        logic wr_con;
        logic wr_aux;
        logic wr_en;
        logic wr_rst;
        logic rd_kbd;
    } strobe_t;
endpackage

// File: rtl/cpw_decode.sv
// Window decoder: matches the address's upper bits against the base switch
// and turns the bus strobes into named per-port strobes.
// Assumes io_rd and io_wr are never high together.
module cpw_decode
    import cpw_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    base_sw,
    input  logic             io_rd,
    input  logic             io_wr,
    output logic             hit,
    output logic [OFS_W-1:0] ofs,
    output strobe_t          stb
);
    localparam int TAG_W = AW - OFS_W;

    logic [TAG_W-1:0] addr_tag;
    logic [TAG_W-1:0] base_tag;
    logic             unused_base_low;

    assign addr_tag        = addr[AW-1:OFS_W];
    assign base_tag        = base_sw[AW-1:OFS_W];
    assign unused_base_low = ^base_sw[OFS_W-1:0];
    assign ofs             = addr[OFS_W-1:0];

    // Window match on the tag bits only.
    always_comb hit = (addr_tag == base_tag);

    // Per-port strobes, qualified by the window match.
    always_comb begin
        stb.wr_con = io_wr && hit && (ofs == OFS_CON_DATA);
        stb.wr_aux = io_wr && hit && (ofs == OFS_AUX_DATA);
        stb.wr_en  = io_wr && hit && (ofs == OFS_AUX_EN);
        stb.wr_rst = io_wr && hit && (ofs == OFS_AUX_RST);
        stb.rd_kbd = io_rd && hit && (ofs == OFS_KBD_DATA);
    end

    // R2: at most one strobe is active for any access.
    always_comb begin
        a_r2_single_strobe: assert ($onehot0(stb));
    end
endmodule

// File: rtl/cpw_char_chan.sv
// One character channel: latches a byte on write and raises a ready flag,
// which the consumer drops by pulling clr_n low. A write beats a clear.
module cpw_char_chan
    import cpw_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] din,
    input  logic          clr_n,
    output logic [DW-1:0] dout,
    output logic          rdy
);
    // Byte latch and ready flag with write priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            rdy  <= 1'b0;
        end else if (wr) begin
            dout <= din;
            rdy  <= 1'b1;
        end else if (!clr_n) begin
            rdy  <= 1'b0;
        end
    end

    a_r5_write_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdy && dout == $past(din)));
    a_r6_clear_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !clr_n) |=> (!rdy && $stable(dout)));
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && clr_n) |=> ($stable(rdy) && $stable(dout)));
endmodule

// File: rtl/cpw_ctrl_regs.sv
// Control bits for the auxiliary display (enable, controller reset) and
// the LED bar copy of the last character with its destination bits.
module cpw_ctrl_regs
    import cpw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LED_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb,
    input  logic [DW-1:0] din,
    output logic          aux_en,
    output logic          aux_rst,
    output logic [LW-1:0] led_bar
);
    localparam int DST_W = LW - DW;
    localparam logic [DST_W-1:0] DST_CON = DST_W'(1 << CH_CON);
    localparam logic [DST_W-1:0] DST_AUX = DST_W'(1 << CH_AUX);

    // Enable and reset bits, each from bit 0 of its own port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_en  <= 1'b0;
            aux_rst <= 1'b0;
        end else begin
            if (stb.wr_en)  aux_en  <= din[0];
            if (stb.wr_rst) aux_rst <= din[0];
        end
    end

    // LED bar follows every character write with a one-hot destination.
    always_ff @(posedge clk) begin
        if (!rst_n)          led_bar <= '0;
        else if (stb.wr_con) led_bar <= {DST_CON, din};
        else if (stb.wr_aux) led_bar <= {DST_AUX, din};
    end

    a_r11_led_console: assert property (@(posedge clk) disable iff (!rst_n)
        stb.wr_con |=> (led_bar == {DST_CON, $past(din)}));
    a_r11_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb.wr_con && !stb.wr_aux) |=> $stable(led_bar));
    a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.wr_en |=> $stable(aux_en));
    a_r9_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.wr_rst |=> $stable(aux_rst));
endmodule

// File: rtl/cpw_read_mux.sv
// Combinational read path: selects the port value by offset and drives
// the bus only for a read inside the window; otherwise returns zero.
module cpw_read_mux
    import cpw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OW = OPT_W
) (
    input  logic             io_rd,
    input  logic             hit,
    input  logic [OFS_W-1:0] ofs,
    input  logic             con_rdy,
    input  logic             kbd_avail,
    input  logic [DW-1:0]    kbd_code,
    input  logic [OW-1:0]    opt_sw,
    input  logic             aux_en,
    input  logic             aux_rst,
    output logic [DW-1:0]    rdata,
    output logic             oe
);
    logic [DW-1:0] sel_val;

    // Per-offset value; unassigned offsets read as zero.
    always_comb begin
        sel_val = '0;
        unique case (ofs)
            OFS_CON_STAT: sel_val = DW'({!con_rdy, kbd_avail});
            OFS_CFG:      sel_val = DW'(opt_sw);
            OFS_AUX_EN:   sel_val = DW'(aux_en);
            OFS_KBD_STAT: sel_val = DW'(kbd_avail);
            OFS_KBD_DATA: sel_val = kbd_code;
            OFS_AUX_RST:  sel_val = DW'(aux_rst);
            default:      sel_val = '0;
        endcase
    end

    // Drive only while reading inside the window.
    always_comb begin
        oe    = io_rd && hit;
        rdata = oe ? sel_val : '0;
    end
endmodule

// File: rtl/cons_port_window.sv
// Top of the relocatable console port window. Wires the decoder, the two
// character channels (generated), the control registers and the read mux.
// Assumes single-cycle bus strobes and a synchronous active-low reset.
module cons_port_window
    import cpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    input  logic [ADDR_W-1:0] base_sw,
    input  logic [OPT_W-1:0]  opt_sw,
    input  logic              kbd_avail,
    input  logic [DATA_W-1:0] kbd_code,
    output logic              kbd_ack,
    output logic [DATA_W-1:0] con_data,
    output logic              con_rdy,
    input  logic              con_clr_n,
    output logic [DATA_W-1:0] aux_data,
    output logic              aux_rdy,
    input  logic              aux_clr_n,
    output logic              aux_en,
    output logic              aux_rst,
    output logic [LED_W-1:0]  led_bar
);
    logic             hit;
    logic [OFS_W-1:0] ofs;
    strobe_t          stb;
    logic [N_CHAN-1:0]             ch_wr;
    logic [N_CHAN-1:0]             ch_clr_n;
    logic [N_CHAN-1:0]             ch_rdy;
    logic [N_CHAN-1:0][DATA_W-1:0] ch_data;

    cpw_decode #(.AW(ADDR_W)) u_dec (
        .addr(addr), .base_sw(base_sw), .io_rd(io_rd), .io_wr(io_wr),
        .hit(hit), .ofs(ofs), .stb(stb)
    );

    // Channel strobe and clear routing by channel index.
    always_comb begin
        ch_wr[CH_CON]    = stb.wr_con;
        ch_wr[CH_AUX]    = stb.wr_aux;
        ch_clr_n[CH_CON] = con_clr_n;
        ch_clr_n[CH_AUX] = aux_clr_n;
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        cpw_char_chan #(.DW(DATA_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .wr(ch_wr[c]), .din(wdata),
            .clr_n(ch_clr_n[c]), .dout(ch_data[c]), .rdy(ch_rdy[c])
        );
    end

    assign con_data = ch_data[CH_CON];
    assign con_rdy  = ch_rdy[CH_CON];
    assign aux_data = ch_data[CH_AUX];
    assign aux_rdy  = ch_rdy[CH_AUX];
    assign kbd_ack  = stb.rd_kbd;

    cpw_ctrl_regs #(.DW(DATA_W), .LW(LED_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .stb(stb), .din(wdata),
        .aux_en(aux_en), .aux_rst(aux_rst), .led_bar(led_bar)
    );

    cpw_read_mux #(.DW(DATA_W), .OW(OPT_W)) u_rd (
        .io_rd(io_rd), .hit(hit), .ofs(ofs), .con_rdy(con_rdy),
        .kbd_avail(kbd_avail), .kbd_code(kbd_code), .opt_sw(opt_sw),
        .aux_en(aux_en), .aux_rst(aux_rst), .rdata(bus_rdata), .oe(bus_oe)
    );

    a_r2_no_drive_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:OFS_W] != base_sw[ADDR_W-1:OFS_W]) |-> (!bus_oe && !kbd_ack));
    a_r2_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_rdata == '0));
    a_r10_ack_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_ack |-> (io_rd && bus_oe && bus_rdata == kbd_code));
    a_r3_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && addr[OFS_W-1:0] == OFS_CON_STAT) |->
            (bus_rdata == DATA_W'({!con_rdy, kbd_avail})));
endmodule

// File: tb/cons_port_window_tb_top.sv
// Self-checking bench: fixed-seed random traffic plus directed corners,
// compared each cycle against a bench-side model of the port window.
module cons_port_window_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0, wdata = '0, base_sw = 8'h80, kbd_code = '0;
    logic       io_rd = 1'b0, io_wr = 1'b0, kbd_avail = 1'b0;
    logic [3:0] opt_sw = '0;
    logic       con_clr_n = 1'b1, aux_clr_n = 1'b1;
    logic [7:0] bus_rdata, con_data, aux_data;
    logic       bus_oe, kbd_ack, con_rdy, aux_rdy, aux_en, aux_rst;
    logic [9:0] led_bar;

    int  n_chk = 0, n_err = 0, cyc = 0;
    bit  done = 1'b0;

    // Model state
    logic [7:0] m_cd = '0, m_ad = '0;
    logic       m_cr = 1'b0, m_ar = 1'b0, m_en = 1'b0, m_rst = 1'b0;
    logic [9:0] m_led = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cons_port_window dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .io_rd(io_rd),
        .io_wr(io_wr), .bus_rdata(bus_rdata), .bus_oe(bus_oe), .base_sw(base_sw),
        .opt_sw(opt_sw), .kbd_avail(kbd_avail), .kbd_code(kbd_code),
        .kbd_ack(kbd_ack), .con_data(con_data), .con_rdy(con_rdy),
        .con_clr_n(con_clr_n), .aux_data(aux_data), .aux_rdy(aux_rdy),
        .aux_clr_n(aux_clr_n), .aux_en(aux_en), .aux_rst(aux_rst), .led_bar(led_bar)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [7:0] a);
        return a[7:4] == base_sw[7:4];
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] o);
        case (o)
            4'h0:    return {6'b0, !m_cr, kbd_avail};
            4'h6:    return {4'b0, opt_sw};
            4'h8:    return {7'b0, m_en};
            4'h9:    return {7'b0, kbd_avail};
            4'hA:    return kbd_code;
            4'hF:    return {7'b0, m_rst};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] o);
        case (o)
            4'h0: return "R3";
            4'h6: return "R4";
            4'h8: return "R7";
            4'h9, 4'hA: return "R10";
            4'hF: return "R9";
            default: return "R13";
        endcase
    endfunction

    task automatic check_state();
        chk("R5",  "con_data", con_data, m_cd);
        chk("R6",  "con_rdy",  con_rdy,  m_cr);
        chk("R8",  "aux_data", aux_data, m_ad);
        chk("R8",  "aux_rdy",  aux_rdy,  m_ar);
        chk("R7",  "aux_en",   aux_en,   m_en);
        chk("R9",  "aux_rst",  aux_rst,  m_rst);
        chk("R11", "led_bar",  led_bar,  m_led);
    endtask

    // One bus cycle: check prior state, drive, check reads, advance model.
    task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [7:0] d, input logic cclr, input logic aclr);
        logic h, wc, wa;
        @(negedge clk);
        check_state();
        io_rd = rd; io_wr = wr; addr = a; wdata = d;
        con_clr_n = cclr; aux_clr_n = aclr;
        #1;
        h = in_win(a);
        chk(h ? "R1" : "R2", "bus_oe", bus_oe, rd && h);
        chk((rd && h) ? read_tag(a[3:0]) : "R2", "bus_rdata", bus_rdata,
            (rd && h) ? exp_read(a[3:0]) : 8'h00);
        chk("R10", "kbd_ack", kbd_ack, rd && h && a[3:0] == 4'hA);
        @(posedge clk);
        wc = wr && h && a[3:0] == 4'h1;
        wa = wr && h && a[3:0] == 4'hE;
        if (wc) begin m_cd = d; m_cr = 1'b1; m_led = {2'b01, d}; end
        else if (!cclr) m_cr = 1'b0;
        if (wa) begin m_ad = d; m_ar = 1'b1; m_led = {2'b10, d}; end
        else if (!aclr) m_ar = 1'b0;
        if (wr && h && a[3:0] == 4'h8) m_en  = d[0];
        if (wr && h && a[3:0] == 4'hF) m_rst = d[0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
        con_clr_n = 1'b1; aux_clr_n = 1'b1;
        repeat (3) @(negedge clk);
        m_cd = '0; m_ad = '0; m_cr = 0; m_ar = 0; m_en = 0; m_rst = 0; m_led = '0;
        chk("R12", "con_rdy at reset", con_rdy, 0);
        chk("R12", "aux_rdy at reset", aux_rdy, 0);
        chk("R12", "led_bar at reset", led_bar, 0);
        chk("R12", "ctrl bits at reset", {aux_en, aux_rst, con_data, aux_data}, 0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240521));
        base_sw = 8'h8B;           // low nibble garbage must not matter (R1)
        do_reset();
        // R5: write, then overwrite while still ready
        step(0, 1, 8'h81, 8'h41, 1, 1);
        step(0, 1, 8'h81, 8'h42, 1, 1);
        // R3: status shows console busy
        kbd_avail = 1'b1;
        step(1, 0, 8'h80, 8'h00, 1, 1);
        // R6: clear, then write and clear in the same edge
        step(0, 0, 8'h00, 8'h00, 0, 1);
        step(0, 1, 8'h81, 8'h43, 0, 1);
        step(0, 0, 8'h00, 8'h00, 1, 1);
        // R8/R11: auxiliary character
        step(0, 1, 8'h8E, 8'h5A, 1, 1);
        step(0, 0, 8'h00, 8'h00, 1, 0);
        // R7/R9: enable and controller reset with readback
        step(0, 1, 8'h88, 8'hFF, 1, 1);
        step(0, 1, 8'h8F, 8'h01, 1, 1);
        step(1, 0, 8'h88, 8'h00, 1, 1);
        step(1, 0, 8'h8F, 8'h00, 1, 1);
        // R4 and R10
        opt_sw = 4'hA; kbd_code = 8'h1C;
        step(1, 0, 8'h86, 8'h00, 1, 1);
        step(1, 0, 8'h89, 8'h00, 1, 1);
        step(1, 0, 8'h8A, 8'h00, 1, 1);
        // R13: unused offsets
        step(0, 1, 8'h85, 8'h77, 1, 1);
        step(1, 0, 8'h8C, 8'h00, 1, 1);
        // R2: outside window ignored
        step(0, 1, 8'h01, 8'h99, 1, 1);
        step(0, 1, 8'h0E, 8'h98, 1, 1);
        step(1, 0, 8'h0A, 8'h00, 1, 1);
        // R1: relocate to 00H, legacy console offsets
        base_sw = 8'h05;
        step(0, 1, 8'h01, 8'h61, 1, 1);
        step(1, 0, 8'h00, 8'h00, 1, 1);
        step(1, 0, 8'h80, 8'h00, 1, 1);
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            logic [1:0] op;
            if ($urandom_range(0, 39) == 0) base_sw = 8'($urandom);
            kbd_avail = 1'($urandom);
            kbd_code  = 8'($urandom);
            opt_sw    = 4'($urandom);
            a  = ($urandom_range(0, 9) < 7) ? {base_sw[7:4], 4'($urandom)} : 8'($urandom);
            op = 2'($urandom_range(0, 2));
            step(op == 1, op == 2, a, 8'($urandom),
                 $urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0);
        end
        // R12: reset mid-run after activity
        step(0, 1, {base_sw[7:4], 4'h1}, 8'h33, 1, 1);
        do_reset();
        step(0, 0, 8'h00, 8'h00, 1, 1);
        @(negedge clk);
        check_state();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule